// File: doc/BRIEF.md
# Two-level vectored interrupt controller

This block picks one of six interrupt sources for an 8-bit microcontroller core and gives the core a request line together with the address to jump to. Each source has an enable bit and a priority bit that selects the low or the high level. A global enable gates all of them. When the core takes the interrupt it pulses an acknowledge. The block records that a service is now running at the level of that source. When the core returns from the handler it pulses a return strobe, and the block ends the innermost running service.

The two external inputs are active low. Each one works either from its level or from a falling edge. In edge mode a high sample followed by a low sample on the next clock sets a latched flag. The two timer overflow inputs are one-cycle pulses that set latched flags. The serial and timer-2 flags are level inputs that software clears at their source. On acknowledge, hardware clears the latched flag of the source that was taken, but only for an edge-mode external or for timer 0 or timer 1. A `pending` output shows each source's request state, so the effect of that clearing can be seen at the ports.

Within one level, the source with the lower index wins. A high-level request may interrupt a low-level service that is running. A request at the same level or at a lower level waits until the running service has returned.

Top module: `irq_arbiter`

## Requirements
- R1: Among eligible requests of one level, the lowest source index wins. The indices are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2. This index is the bit position in `src_en`, `src_hi` and `pending`.
- R2: `vector` equals 8*index+3: 03h, 0Bh, 13h, 1Bh, 23h and 2Bh for indices 0 to 5.
- R3: The external input k (`ext_n[k]`) maps to pending bit 2k. With `ext_edge[k]`=1, a high sample followed by a low sample on consecutive clocks sets that bit, and a pin held low does not set it again. With `ext_edge[k]`=0, the bit is 1 exactly while the pin is low.
- R4: On acknowledge, the pending bit of an external source is cleared only in edge mode. In level mode it stays 1 while the pin is low.
- R5: On acknowledge, the timer 0 and timer 1 flags (pending bits 1 and 3, set by pulses on `tmr_ovf[0]` and `tmr_ovf[1]`) are cleared. The serial and timer-2 bits follow their inputs and are never cleared by the block.
- R6: `irq` is not raised while `glb_en` is 0, or for a source whose `src_en` bit is 0.
- R7: While a service runs at a level, no request at that level or below it raises `irq` until a return strobe ends that service.
- R8: A high-level request raises `irq` while a low-level service runs. The return strobe clears only the innermost in-service level, so after the high-level service returns, the low-level service still blocks other low-level requests.
- R9: Once `irq` rises, it and `vector` hold their values until an acknowledge, even if higher-priority requests arrive in the meantime.
- R10: After reset, `irq` is 0, `pending` is 0 while the inputs are idle, and nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_n | input | 2 | External interrupt pins, active low |
| ext_edge | input | 2 | Per external pin: 1 edge mode, 0 level mode |
| tmr_ovf | input | 2 | Timer 0/1 overflow set pulses |
| ser_flag | input | 1 | Serial receive/transmit flag (software cleared) |
| tm2_flag | input | 1 | Timer 2 flag (software cleared) |
| src_en | input | 6 | Per-source enable, by source index |
| src_hi | input | 6 | Per-source priority, 1 = high level |
| glb_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Core takes the request |
| reti | input | 1 | Core returns from a handler |
| irq | output | 1 | Interrupt request to the core |
| vector | output | 8 | Handler address of the requested source |
| pending | output | 6 | Request state per source index |

## Verification
In the first pattern, all six sources are pending at the low level when the global enable turns on. The bench then expects the services to come out one at a time, in index order, with one return between each pair. This separates the polling order and the vector encoding from the blocking at an equal level. In the same run, a level-mode external input and an edge-mode one are both acknowledged, alongside timer and software-cleared flags, which shows which flags the hardware clears. A second pattern nests a high-level timer inside a serial service and then makes another high-level timer wait. It shows that a return strobe ends only the inner level. A third pattern keeps a request unacknowledged while a higher-priority source arrives, and it also masks one source by its enable bit, to test that the vector is held and that masking works.

// File: rtl/irq_pkg.sv
// Shared constants and helpers for the interrupt controller.
// Assumes a fixed set of six sources, with polling index equal to bit position.
package irq_pkg;
    localparam int NSRC  = 6;
    localparam int IDX_W = $clog2(NSRC);
    localparam int VEC_W = 8;
    localparam int NEXT  = 2;   // external pins, mapped to even indices
    localparam int NLVL  = 2;   // priority levels

    // Handler address for a source: spacing of eight, offset of three.
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return (VEC_W'(idx) << 3) | VEC_W'(3);
    endfunction
endpackage

// File: rtl/irq_flags.sv
// Request flag keeping. External pin k and timer k sit at indices 2k and 2k+1.
// Serial and timer-2 flags pass straight through at indices 4 and 5.
// Assumes the pins are already synchronous to clk.
module irq_flags
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEXT-1:0]  ext_n,
    input  logic [NEXT-1:0]  ext_edge,
    input  logic [NEXT-1:0]  tmr_ovf,
    input  logic             ser_flag,
    input  logic             tm2_flag,
    input  logic             clr_stb,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NSRC-1:0]  pend
);
    logic [NEXT-1:0] prev_n;
    logic [NEXT-1:0] eflag;
    logic [NEXT-1:0] tflag;

    // Remember the previous pin sample for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= '1;
        else        prev_n <= ext_n;
    end

    for (genvar k = 0; k < NEXT; k++) begin : g_pair
        localparam logic [IDX_W-1:0] EIDX = IDX_W'(2*k);
        localparam logic [IDX_W-1:0] TIDX = IDX_W'(2*k+1);
        logic fall;
        assign fall = prev_n[k] & ~ext_n[k];

        // Edge-mode latch: set on a falling edge, cleared when acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n || !ext_edge[k])         eflag[k] <= 1'b0;
            else if (fall)                      eflag[k] <= 1'b1;
            else if (clr_stb && clr_idx == EIDX) eflag[k] <= 1'b0;
        end

        // Timer overflow latch: set by a pulse, cleared when acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n)                          tflag[k] <= 1'b0;
            else if (tmr_ovf[k])                 tflag[k] <= 1'b1;
            else if (clr_stb && clr_idx == TIDX) tflag[k] <= 1'b0;
        end

        assign pend[2*k]   = ext_edge[k] ? eflag[k] : ~ext_n[k];
        assign pend[2*k+1] = tflag[k];
    end

    assign pend[4] = ser_flag;
    assign pend[5] = tm2_flag;
endmodule

// File: rtl/irq_select.sv
// Combinational arbiter: picks the winning source given the levels in service.
// High level is tried first; the lowest index within a level wins.
module irq_select
    import irq_pkg::*;
(
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NSRC-1:0]  src_hi,
    input  logic             glb_en,
    input  logic [NLVL-1:0]  in_svc,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_hi
);
    logic [NSRC-1:0] elig, hi_c, lo_c, pool;

    // Pick the candidate pool allowed by the running levels, then the lowest index.
    always_comb begin
        elig   = pend & src_en & {NSRC{glb_en}};
        hi_c   = elig & src_hi;
        lo_c   = elig & ~src_hi;
        win_hi = ~in_svc[1] & (|hi_c);
        if (win_hi)          pool = hi_c;
        else if (~|in_svc)   pool = lo_c;
        else                 pool = '0;
        win_idx = '0;
        for (int i = NSRC-1; i >= 0; i--) begin
            if (pool[i]) win_idx = IDX_W'(i);
        end
        win_valid = |pool;
    end
endmodule

// File: rtl/irq_nest.sv
// In-service tracking: bit 0 low level, bit 1 high level.
// A take sets the taken level; a return clears the innermost set level.
module irq_nest
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            take_hi,
    input  logic            reti,
    output logic [NLVL-1:0] in_svc
);
    logic [NLVL-1:0] nxt;

    // Clear on return first, then record a newly taken level.
    always_comb begin
        nxt = in_svc;
        if (reti) begin
            if (nxt[1]) nxt[1] = 1'b0;
            else        nxt[0] = 1'b0;
        end
        if (take) nxt[take_hi] = 1'b1;
    end

    // Register the in-service state.
    always_ff @(posedge clk) begin
        if (!rst_n) in_svc <= '0;
        else        in_svc <= nxt;
    end
endmodule

// File: rtl/irq_arbiter.sv
// Top of the two-level vectored interrupt controller.
// Latches the winner into a held request until the core acknowledges it.
// Assumes ack is only meaningful while irq is high.
module irq_arbiter
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEXT-1:0]  ext_n,
    input  logic [NEXT-1:0]  ext_edge,
    input  logic [NEXT-1:0]  tmr_ovf,
    input  logic             ser_flag,
    input  logic             tm2_flag,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NSRC-1:0]  src_hi,
    input  logic             glb_en,
    input  logic             ack,
    input  logic             reti,
    output logic             irq,
    output logic [VEC_W-1:0] vector,
    output logic [NSRC-1:0]  pending
);
    logic             req_q, hi_q, take;
    logic [IDX_W-1:0] idx_q;
    logic             win_valid, win_hi;
    logic [IDX_W-1:0] win_idx;
    logic [NLVL-1:0]  in_svc;

    assign take = req_q & ack;

    irq_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge(ext_edge),
        .tmr_ovf(tmr_ovf), .ser_flag(ser_flag), .tm2_flag(tm2_flag),
        .clr_stb(take), .clr_idx(idx_q), .pend(pending)
    );

    irq_select u_sel (
        .pend(pending), .src_en(src_en), .src_hi(src_hi), .glb_en(glb_en),
        .in_svc(in_svc), .win_valid(win_valid), .win_idx(win_idx), .win_hi(win_hi)
    );

    irq_nest u_nest (
        .clk(clk), .rst_n(rst_n), .take(take), .take_hi(hi_q),
        .reti(reti), .in_svc(in_svc)
    );

    // Hold request: capture a winner while idle, drop it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            idx_q <= '0;
            hi_q  <= 1'b0;
        end else if (req_q) begin
            if (ack) req_q <= 1'b0;
        end else if (win_valid) begin
            req_q <= 1'b1;
            idx_q <= win_idx;
            hi_q  <= win_hi;
        end
    end

    assign irq    = req_q;
    assign vector = vec_of(idx_q);
endmodule

// File: rtl/irq_arbiter_chk.sv
// Property checker for irq_arbiter, attached by bind.
module irq_arbiter_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NEXT-1:0]  ext_n,
    input logic [NEXT-1:0]  ext_edge,
    input logic [NEXT-1:0]  tmr_ovf,
    input logic             glb_en,
    input logic             ack,
    input logic             irq,
    input logic [VEC_W-1:0] vector,
    input logic [NSRC-1:0]  pending,
    input logic [NLVL-1:0]  in_svc
);
    p_vec_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vector[2:0] == 3'b011 && vector[7:3] < 5'd6));

    p_edge_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack && vector == 8'h03 && ext_edge[0] && ext_n[0])
        |=> (!ext_edge[0] || !pending[0]));

    p_tmr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack && vector == 8'h0B && !tmr_ovf[0]) |=> !pending[1]);

    p_glb_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(glb_en));

    p_hi_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_svc[1] && !irq) |=> !irq);

    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> (irq && $stable(vector)));
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .glb_en(glb_en), .ack(ack), .irq(irq),
    .vector(vector), .pending(pending), .in_svc(in_svc)
);

// File: tb/irq_arbiter_test.sv
// Scoreboard bench: the driver queues expected vectors, the monitor acknowledges and compares.
module irq_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_n = 2'b11, ext_edge = 2'b00, tmr_ovf = 2'b00;
    logic       ser_flag = 1'b0, tm2_flag = 1'b0;
    logic [5:0] src_en = 6'h3F, src_hi = 6'h00;
    logic       glb_en = 1'b0, ack = 1'b0, reti = 1'b0;
    logic       irq;
    logic [7:0] vector;
    logic [5:0] pending;

    typedef struct { logic [7:0] vec; string tag; } exp_t;
    exp_t exp_q[$];
    int checks = 0, errors = 0, served = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_arbiter uut (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge(ext_edge),
        .tmr_ovf(tmr_ovf), .ser_flag(ser_flag), .tm2_flag(tm2_flag),
        .src_en(src_en), .src_hi(src_hi), .glb_en(glb_en), .ack(ack),
        .reti(reti), .irq(irq), .vector(vector), .pending(pending)
    );

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Queue one expected service and wait until the monitor has taken it.
    task automatic serve(logic [7:0] vec, string tag);
        int start;
        exp_t e;
        e.vec = vec; e.tag = tag;
        start = served;
        exp_q.push_back(e);
        while (served == start) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reti();
        reti = 1'b1; tick(1); reti = 1'b0; tick(1);
    endtask

    task automatic pulse_tmr(int k);
        tmr_ovf[k] = 1'b1; tick(1); tmr_ovf[k] = 1'b0;
    endtask

    // Monitor: acknowledge a raised request when an expectation is queued.
    initial begin
        forever begin
            @(negedge clk);
            if (ack) ack = 1'b0;
            else if (irq && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check_eq(e.tag, {24'd0, vector}, {24'd0, e.vec});
                ack = 1'b1;
                served++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check_eq("R10 irq after reset", {31'd0, irq}, 32'd0);
        check_eq("R10 pending after reset", {26'd0, pending}, 32'd0);

        // Pattern 1: all six pending at low level, global enable off.
        ext_edge = 2'b01;
        tick(1);
        ext_n[0] = 1'b0;              // falling edge, edge mode
        ext_n[1] = 1'b0;              // level mode, held low
        pulse_tmr(0); pulse_tmr(1);
        ser_flag = 1'b1; tm2_flag = 1'b1;
        tick(3);
        check_eq("R3 R6 all pending, glb off", {26'd0, pending}, 32'h3F);
        check_eq("R6 no irq with glb_en 0", {31'd0, irq}, 32'd0);
        glb_en = 1'b1;
        serve(8'h03, "R1 R2 ext0 first");
        check_eq("R4 edge ext0 cleared", {31'd0, pending[0]}, 32'd0);
        tick(4);
        check_eq("R7 equal level waits", {31'd0, irq}, 32'd0);
        check_eq("R3 held-low edge pin not re-set", {31'd0, pending[0]}, 32'd0);
        ext_n[0] = 1'b1;
        do_reti();
        serve(8'h0B, "R1 R2 timer0 second");
        check_eq("R5 timer0 cleared", {31'd0, pending[1]}, 32'd0);
        do_reti();
        serve(8'h13, "R1 R2 ext1 third");
        check_eq("R4 level ext1 kept", {31'd0, pending[2]}, 32'd1);
        ext_n[1] = 1'b1;
        tick(1);
        check_eq("R3 level follows pin", {31'd0, pending[2]}, 32'd0);
        do_reti();
        serve(8'h1B, "R1 R2 timer1 fourth");
        check_eq("R5 timer1 cleared", {31'd0, pending[3]}, 32'd0);
        do_reti();
        serve(8'h23, "R1 R2 serial fifth");
        check_eq("R5 serial not cleared", {31'd0, pending[4]}, 32'd1);
        ser_flag = 1'b0;
        do_reti();
        serve(8'h2B, "R1 R2 timer2 sixth");
        check_eq("R5 timer2 not cleared", {31'd0, pending[5]}, 32'd1);
        tm2_flag = 1'b0;
        do_reti();
        tick(3);
        check_eq("R7 idle after all returns", {31'd0, irq}, 32'd0);

        // Pattern 2: nesting.
        src_hi = 6'b001010;           // timers 0 and 1 high
        ser_flag = 1'b1;
        serve(8'h23, "R8 serial low service");
        pulse_tmr(0);
        serve(8'h0B, "R8 timer0 pre-empts low");
        pulse_tmr(1);
        tick(4);
        check_eq("R7 high level waits in high", {31'd0, irq}, 32'd0);
        do_reti();
        serve(8'h1B, "R8 timer1 after high return");
        do_reti();
        tick(4);
        check_eq("R8 low still in service", {31'd0, irq}, 32'd0);
        ser_flag = 1'b0;
        do_reti();
        tick(2);

        // Pattern 3: source mask and vector hold.
        src_en = 6'b011111;
        tm2_flag = 1'b1;
        tick(4);
        check_eq("R6 masked source no irq", {31'd0, irq}, 32'd0);
        check_eq("R6 masked source still pending", {31'd0, pending[5]}, 32'd1);
        src_en = 6'h3F;
        serve(8'h2B, "R6 timer2 after enable");
        tm2_flag = 1'b0;
        do_reti();
        ser_flag = 1'b1;
        tick(3);
        check_eq("R9 serial raised", {31'd0, irq}, 32'd1);
        pulse_tmr(0);
        tick(3);
        check_eq("R9 vector held", {24'd0, vector}, 32'h23);
        check_eq("R9 irq held", {31'd0, irq}, 32'd1);
        serve(8'h23, "R9 held serial taken");
        serve(8'h0B, "R8 timer0 pre-empts after hold");
        ser_flag = 1'b0;
        do_reti();
        do_reti();
        tick(3);
        check_eq("R7 idle at end", {31'd0, irq}, 32'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule